// File: doc/BRIEF.md
# Relative-Addressed Extended-Precision Register Stack

This block stores eight 80-bit extended-precision values (64-bit mantissa) as a circular stack. A 3-bit top pointer selects the physical slot that is currently the accumulator. Every other register is named by its distance from the top, st0 to st7, and st(i) lives in physical slot (top + i) mod 8. A loaded value is pushed by moving the top down one slot and writing there. A stored value is popped by emptying the top slot and moving the top up. An arithmetic unit beside the block reads st0 and a chosen st(i) and returns its result to any st(i), popping in the same cycle if it asks. An exchange swaps st0 with any st(i), so any register can become the accumulator. A valid tag on each physical slot lets the block detect stack overflow and underflow. When either condition is detected, the flag is raised and nothing is changed.

The same storage can also be used as a flat integer register file. Entering that mode moves the top to slot 0 and marks every slot valid. st(i) then equals physical slot i, and an alias write replaces the low 64 bits of one slot. Stack operations have no effect while the alias mode is active. A separate command empties every tag. All reads are combinational. All writes take effect on the rising clock edge, so a read in the same cycle as a write returns the old contents. The depth must be a power of two for the natural pointer wrap; other depths use an explicit modulo.

Top module: `fpstk_top`

## Requirements
- R1: After reset, top_o is 0, tags_o is all zero, alias_mode_o is 0, and overflow_o and underflow_o are 0.
- R2: op_i = 1 (push) in stack mode with the target slot empty decrements top_o at the clock edge, writes push_data_i into the new st0 and sets that slot's tag bit. tags_o bit k belongs to physical slot k.
- R3: A push whose target slot (top - 1) already has its tag set raises overflow_o in that cycle, and leaves top_o, tags_o and all contents unchanged.
- R4: op_i = 2 (pop) presents the value being removed on st0_o in that cycle. At the edge it clears the tag of st0 and increments top_o.
- R5: underflow_o is raised, and nothing changes, when a pop finds st0 empty, or when op_i = 3 (operand read) or op_i = 5 (exchange) finds st0 or st(idx_i) empty.
- R6: st0_o shows physical slot top_o, and sti_o shows physical slot (top_o + idx_i) mod 8, both combinationally.
- R7: op_i = 4 (write-back) writes wb_data_i to st(idx_i) and sets its tag. If wb_pop_i is 1, the same edge then clears the tag of st0 and increments top_o.
- R8: op_i = 5 with both entries valid swaps the contents of st0 and st(idx_i) at one edge, leaving top_o and tags_o unchanged.
- R9: In a cycle that writes an entry, st0_o and sti_o still show the entry's old contents until the clock edge.
- R10: op_i = 6 (clear) sets every tag bit to 0 and leaves top_o unchanged.
- R11: op_i = 7 enters the alias mode: top_o becomes 0, every tag bit becomes 1 and alias_mode_o becomes 1. While the alias mode is active, ops 1 to 5 change nothing and raise no flag.
- R12: op_i = 9 in the alias mode replaces bits 63:0 of physical slot idx_i with wb_data_i[63:0] and keeps bits 79:64. op_i = 9 in stack mode is ignored. op_i = 8 leaves the alias mode and keeps top_o and tags_o. Codes 0 and 10 to 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code for this cycle |
| idx_i | input | 3 | Relative index i for st(i); physical slot in alias mode |
| push_data_i | input | 80 | Value to push |
| wb_data_i | input | 80 | Write-back result; low 64 bits for alias writes |
| wb_pop_i | input | 1 | Pop after write-back |
| st0_o | output | 80 | Contents of st0 |
| sti_o | output | 80 | Contents of st(idx_i) |
| top_o | output | 3 | Current top pointer |
| tags_o | output | 8 | Valid tag of each physical slot |
| alias_mode_o | output | 1 | 1 while the integer alias mode is active |
| overflow_o | output | 1 | Push onto an occupied slot this cycle |
| underflow_o | output | 1 | Access to an empty slot this cycle |

## Verification
On every cycle, the assertions check four things: that a raised overflow or underflow freezes the pointer and tags, that an accepted push moves the top down and lands its data in st0, that entering the alias mode and clearing set the tags as required, and that stack operations are inert in the alias mode. Only the bench scenarios show the relative-to-physical mapping across a full stack, the exchange and write-back contents, the old value read in a writing cycle, and the 64-bit alias write that keeps the upper 16 bits.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP       = 4'd0,
        OP_PUSH      = 4'd1,
        OP_POP       = 4'd2,
        OP_READ      = 4'd3,
        OP_WB        = 4'd4,
        OP_XCHG      = 4'd5,
        OP_CLEAR     = 4'd6,
        OP_ALIAS_ON  = 4'd7,
        OP_ALIAS_OFF = 4'd8,
        OP_ALIAS_WR  = 4'd9
    } fpstk_op_e;

endpackage

// File: rtl/fpstk_map.sv
module fpstk_map #(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [IDXW-1:0] top_i,
    input  logic [IDXW-1:0] idx_i,
    output logic [IDXW-1:0] phys_st0_o,
    output logic [IDXW-1:0] phys_sti_o,
    output logic [IDXW-1:0] phys_push_o
);

    assign phys_st0_o = top_i;

    generate
        if ((1 << IDXW) == DEPTH) begin : g_pow2
            // natural wrap of the pointer width
            assign phys_sti_o  = top_i + idx_i;
            assign phys_push_o = top_i - IDXW'(1);
        end else begin : g_mod
            logic [IDXW:0] sum_w;
            always_comb begin
                sum_w = {1'b0, top_i} + {1'b0, idx_i};
                if (sum_w >= (IDXW+1)'(DEPTH)) sum_w = sum_w - (IDXW+1)'(DEPTH);
            end
            assign phys_sti_o  = sum_w[IDXW-1:0];
            assign phys_push_o = (top_i == '0) ? IDXW'(DEPTH - 1) : top_i - IDXW'(1);
        end
    endgenerate

endmodule

// File: rtl/fpstk_store.sv
module fpstk_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 80,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we0_i,
    input  logic [IDXW-1:0]  wa0_i,
    input  logic [WIDTH-1:0] wd0_i,
    input  logic             we1_i,
    input  logic [IDXW-1:0]  wa1_i,
    input  logic [WIDTH-1:0] wd1_i,
    input  logic [IDXW-1:0]  ra0_i,
    input  logic [IDXW-1:0]  ra1_i,
    output logic [WIDTH-1:0] rd0_o,
    output logic [WIDTH-1:0] rd1_o
);

    logic [WIDTH-1:0] slot_q [DEPTH];

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_slot
            logic [WIDTH-1:0] slot_d;
            always_comb begin
                slot_d = slot_q[k];
                if (we0_i && wa0_i == IDXW'(k)) slot_d = wd0_i;
                if (we1_i && wa1_i == IDXW'(k)) slot_d = wd1_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) slot_q[k] <= '0;
                else        slot_q[k] <= slot_d;
            end
        end
    endgenerate

    assign rd0_o = slot_q[ra0_i];
    assign rd1_o = slot_q[ra1_i];

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int WIDTH   = 80,
    parameter int ALIAS_W = 64,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic [WIDTH-1:0] wb_data_i,
    input  logic             wb_pop_i,
    input  logic [IDXW-1:0]  phys_st0_i,
    input  logic [IDXW-1:0]  phys_sti_i,
    input  logic [IDXW-1:0]  phys_push_i,
    input  logic [WIDTH-1:0] st0_val_i,
    input  logic [WIDTH-1:0] sti_val_i,
    output logic [IDXW-1:0]  top_o,
    output logic [DEPTH-1:0] tags_o,
    output logic             alias_o,
    output logic             overflow_o,
    output logic             underflow_o,
    output logic             we0_o,
    output logic [IDXW-1:0]  wa0_o,
    output logic [WIDTH-1:0] wd0_o,
    output logic             we1_o,
    output logic [IDXW-1:0]  wa1_o,
    output logic [WIDTH-1:0] wd1_o
);

    typedef struct packed {
        logic [IDXW-1:0]  top;
        logic [DEPTH-1:0] tags;
        logic             alias_on;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    fpstk_op_e   op_w;
    logic        st0_full_w, sti_full_w, push_busy_w;

    assign op_w        = fpstk_op_e'(op_i);
    assign st0_full_w  = st_q.tags[phys_st0_i];
    assign sti_full_w  = st_q.tags[phys_sti_i];
    assign push_busy_w = st_q.tags[phys_push_i];

    always_comb begin
        st_d        = st_q;
        overflow_o  = 1'b0;
        underflow_o = 1'b0;
        we0_o       = 1'b0;
        wa0_o       = phys_st0_i;
        wd0_o       = wb_data_i;
        we1_o       = 1'b0;
        wa1_o       = phys_sti_i;
        wd1_o       = st0_val_i;

        case (op_w)
            OP_PUSH: if (!st_q.alias_on) begin
                if (push_busy_w) begin
                    overflow_o = 1'b1;
                end else begin
                    st_d.top               = phys_push_i;
                    st_d.tags[phys_push_i] = 1'b1;
                    we0_o = 1'b1;
                    wa0_o = phys_push_i;
                    wd0_o = push_data_i;
                end
            end
            OP_POP: if (!st_q.alias_on) begin
                if (!st0_full_w) begin
                    underflow_o = 1'b1;
                end else begin
                    st_d.tags[phys_st0_i] = 1'b0;
                    st_d.top              = phys_st0_i + IDXW'(1);
                end
            end
            OP_READ: if (!st_q.alias_on) begin
                underflow_o = !st0_full_w || !sti_full_w;
            end
            OP_WB: if (!st_q.alias_on) begin
                we0_o = 1'b1;
                wa0_o = phys_sti_i;
                wd0_o = wb_data_i;
                st_d.tags[phys_sti_i] = 1'b1;
                if (wb_pop_i) begin
                    // the pop is applied after the write, so st0 as target ends empty
                    st_d.tags[phys_st0_i] = 1'b0;
                    st_d.top              = phys_st0_i + IDXW'(1);
                end
            end
            OP_XCHG: if (!st_q.alias_on) begin
                if (!st0_full_w || !sti_full_w) begin
                    underflow_o = 1'b1;
                end else begin
                    we0_o = 1'b1;
                    wa0_o = phys_st0_i;
                    wd0_o = sti_val_i;
                    we1_o = 1'b1;
                    wa1_o = phys_sti_i;
                    wd1_o = st0_val_i;
                end
            end
            OP_CLEAR: begin
                st_d.tags = '0;
            end
            OP_ALIAS_ON: begin
                st_d.alias_on = 1'b1;
                st_d.top      = '0;
                st_d.tags     = '1;
            end
            OP_ALIAS_OFF: begin
                st_d.alias_on = 1'b0;
            end
            OP_ALIAS_WR: if (st_q.alias_on) begin
                // top is zero in alias mode, so the relative slot is the physical one
                we0_o = 1'b1;
                wa0_o = phys_sti_i;
                wd0_o = {sti_val_i[WIDTH-1:ALIAS_W], wb_data_i[ALIAS_W-1:0]};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{top: '0, tags: '0, alias_on: 1'b0};
        else        st_q <= st_d;
    end

    assign top_o   = st_q.top;
    assign tags_o  = st_q.tags;
    assign alias_o = st_q.alias_on;

endmodule

// File: rtl/fpstk_top.sv
module fpstk_top
    import fpstk_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int WIDTH   = 80,
    parameter int ALIAS_W = 64,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [IDXW-1:0]  idx_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic [WIDTH-1:0] wb_data_i,
    input  logic             wb_pop_i,
    output logic [WIDTH-1:0] st0_o,
    output logic [WIDTH-1:0] sti_o,
    output logic [IDXW-1:0]  top_o,
    output logic [DEPTH-1:0] tags_o,
    output logic             alias_mode_o,
    output logic             overflow_o,
    output logic             underflow_o
);

    logic [IDXW-1:0]  phys_st0_w, phys_sti_w, phys_push_w;
    logic             we0_w, we1_w;
    logic [IDXW-1:0]  wa0_w, wa1_w;
    logic [WIDTH-1:0] wd0_w, wd1_w;

    fpstk_map #(.DEPTH(DEPTH)) map_i (
        .top_i       (top_o),
        .idx_i       (idx_i),
        .phys_st0_o  (phys_st0_w),
        .phys_sti_o  (phys_sti_w),
        .phys_push_o (phys_push_w)
    );

    fpstk_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we0_i (we0_w),
        .wa0_i (wa0_w),
        .wd0_i (wd0_w),
        .we1_i (we1_w),
        .wa1_i (wa1_w),
        .wd1_i (wd1_w),
        .ra0_i (phys_st0_w),
        .ra1_i (phys_sti_w),
        .rd0_o (st0_o),
        .rd1_o (sti_o)
    );

    fpstk_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ALIAS_W(ALIAS_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_i),
        .push_data_i (push_data_i),
        .wb_data_i   (wb_data_i),
        .wb_pop_i    (wb_pop_i),
        .phys_st0_i  (phys_st0_w),
        .phys_sti_i  (phys_sti_w),
        .phys_push_i (phys_push_w),
        .st0_val_i   (st0_o),
        .sti_val_i   (sti_o),
        .top_o       (top_o),
        .tags_o      (tags_o),
        .alias_o     (alias_mode_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o),
        .we0_o       (we0_w),
        .wa0_o       (wa0_w),
        .wd0_o       (wd0_w),
        .we1_o       (we1_w),
        .wa1_o       (wa1_w),
        .wd1_o       (wd1_w)
    );

endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 80,
    localparam int IDXW = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] push_data_i,
    input logic [WIDTH-1:0] st0_o,
    input logic [IDXW-1:0]  top_o,
    input logic [DEPTH-1:0] tags_o,
    input logic             alias_mode_o,
    input logic             overflow_o,
    input logic             underflow_o
);

    assert_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1 && !alias_mode_o && !overflow_o)
        |=> (top_o == IDXW'($past(top_o) - IDXW'(1))) && (st0_o == $past(push_data_i)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> $stable(top_o) && $stable(tags_o));

    assert_frozen_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> $stable(top_o) && $stable(tags_o));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd6) |=> (tags_o == '0) && $stable(top_o));

    assert_alias_enter_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd7) |=> alias_mode_o && (top_o == '0) && (&tags_o));

    assert_alias_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_mode_o && op_i >= 4'd1 && op_i <= 4'd5)
        |-> !overflow_o && !underflow_o ##1 $stable(top_o) && $stable(tags_o));

    assert_flags_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow_o && underflow_o));

endmodule

bind fpstk_top fpstk_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .push_data_i  (push_data_i),
    .st0_o        (st0_o),
    .top_o        (top_o),
    .tags_o       (tags_o),
    .alias_mode_o (alias_mode_o),
    .overflow_o   (overflow_o),
    .underflow_o  (underflow_o)
);

// File: tb/fpstk_top_tb_top.sv
`timescale 1ns/1ps
module fpstk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [2:0]  idx_i = 3'd0;
    logic [79:0] push_data_i = '0;
    logic [79:0] wb_data_i = '0;
    logic        wb_pop_i = 1'b0;
    logic [79:0] st0_o, sti_o;
    logic [2:0]  top_o;
    logic [7:0]  tags_o;
    logic        alias_mode_o, overflow_o, underflow_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpstk_top dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i),
        .push_data_i(push_data_i), .wb_data_i(wb_data_i), .wb_pop_i(wb_pop_i),
        .st0_o(st0_o), .sti_o(sti_o), .top_o(top_o), .tags_o(tags_o),
        .alias_mode_o(alias_mode_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    function automatic logic [79:0] val(int k);
        return {16'h3FF0 + 16'(k), 64'hA5A5_0000_0000_0000 + 64'(k)};
    endfunction

    task automatic check(string req, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // set up an operation away from the edge; combinational outputs settle after 1 ns
    task automatic setop(logic [3:0] op, logic [2:0] idx, logic [79:0] pd,
                         logic [79:0] wd, logic pop);
        @(negedge clk);
        op_i = op; idx_i = idx; push_data_i = pd; wb_data_i = wd; wb_pop_i = pop;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        op_i = 4'd0; wb_pop_i = 1'b0;
        #0.5;
    endtask

    task automatic peek(logic [2:0] idx);
        idx_i = idx;
        #0.2;
    endtask

    task automatic t_reset();
        check("R1 top", 80'(top_o), 80'd0);
        check("R1 tags", 80'(tags_o), 80'd0);
        check("R1 mode", 80'(alias_mode_o), 80'd0);
        check("R1 flags", 80'({overflow_o, underflow_o}), 80'd0);
    endtask

    task automatic t_push_pop();
        setop(4'd1, 3'd0, val(20), '0, 1'b0); tick();
        check("R2 top after push", 80'(top_o), 80'd7);
        check("R2 tag set", 80'(tags_o), 80'h80);
        check("R2 st0 data", st0_o, val(20));
        setop(4'd1, 3'd1, val(21), '0, 1'b0); tick();
        check("R2 second push top", 80'(top_o), 80'd6);
        peek(3'd1);
        check("R6 st1 is older value", sti_o, val(20));
        setop(4'd2, 3'd0, '0, '0, 1'b0);
        check("R4 pop presents value", st0_o, val(21));
        tick();
        check("R4 pop top", 80'(top_o), 80'd7);
        check("R4 pop tag", 80'(tags_o), 80'h80);
        check("R4 new st0", st0_o, val(20));
        setop(4'd2, 3'd0, '0, '0, 1'b0); tick();
        check("R4 empty again", 80'({top_o, tags_o}), 80'd0);
    endtask

    task automatic t_underflow();
        setop(4'd2, 3'd0, '0, '0, 1'b0);
        check("R5 pop on empty flags", 80'(underflow_o), 80'd1);
        tick();
        check("R5 pop on empty no change", 80'({top_o, tags_o}), 80'd0);
        setop(4'd3, 3'd3, '0, '0, 1'b0);
        check("R5 read empty flags", 80'(underflow_o), 80'd1);
        tick();
        check("R5 read no change", 80'({top_o, tags_o}), 80'd0);
    endtask

    task automatic t_fill_overflow();
        for (int k = 0; k < 8; k++) begin
            setop(4'd1, 3'd0, val(k), '0, 1'b0);
            tick();
        end
        check("R2 full top", 80'(top_o), 80'd0);
        check("R2 full tags", 80'(tags_o), 80'hFF);
        for (int i = 0; i < 8; i++) begin
            peek(3'(i));
            check("R6 mapping", sti_o, val(7 - i));
        end
        setop(4'd1, 3'd0, val(99), '0, 1'b0);
        check("R3 overflow raised", 80'(overflow_o), 80'd1);
        tick();
        check("R3 top kept", 80'(top_o), 80'd0);
        check("R3 st0 kept", st0_o, val(7));
    endtask

    task automatic t_xchg_wb();
        setop(4'd5, 3'd3, '0, '0, 1'b0);
        check("R9 st0 old during exchange", st0_o, val(7));
        tick();
        check("R8 st0 swapped", st0_o, val(4));
        peek(3'd3);
        check("R8 st3 swapped", sti_o, val(7));
        check("R8 top kept", 80'(top_o), 80'd0);
        setop(4'd4, 3'd2, '0, 80'h1234_5555_6666_7777_8888, 1'b0);
        check("R9 st2 old during write-back", sti_o, val(5));
        tick();
        peek(3'd2);
        check("R7 st2 written", sti_o, 80'h1234_5555_6666_7777_8888);
        check("R7 no pop top", 80'(top_o), 80'd0);
        setop(4'd4, 3'd1, '0, 80'h4321_AAAA_BBBB_CCCC_DDDD, 1'b1);
        tick();
        check("R7 pop top", 80'(top_o), 80'd1);
        check("R7 pop tags", 80'(tags_o), 80'hFE);
        check("R7 result in st0", st0_o, 80'h4321_AAAA_BBBB_CCCC_DDDD);
    endtask

    task automatic t_clear();
        setop(4'd6, 3'd0, '0, '0, 1'b0); tick();
        check("R10 tags empty", 80'(tags_o), 80'd0);
        check("R10 top kept", 80'(top_o), 80'd1);
        setop(4'd3, 3'd0, '0, '0, 1'b0);
        check("R5 read after clear", 80'(underflow_o), 80'd1);
        tick();
    endtask

    task automatic t_alias();
        setop(4'd7, 3'd0, '0, '0, 1'b0); tick();
        check("R11 top zero", 80'(top_o), 80'd0);
        check("R11 tags full", 80'(tags_o), 80'hFF);
        check("R11 mode on", 80'(alias_mode_o), 80'd1);
        setop(4'd1, 3'd0, val(50), '0, 1'b0);
        check("R11 push no flag", 80'({overflow_o, underflow_o}), 80'd0);
        tick();
        check("R11 push ignored", 80'(top_o), 80'd0);
        check("R11 push no data", st0_o, val(4));
        setop(4'd9, 3'd5, '0, 80'hFFFF_DEAD_BEEF_0123_4567, 1'b0); tick();
        peek(3'd5);
        check("R12 alias write keeps upper", sti_o, {16'h3FF2, 64'hDEAD_BEEF_0123_4567});
        setop(4'd8, 3'd0, '0, '0, 1'b0); tick();
        check("R12 mode off", 80'(alias_mode_o), 80'd0);
        check("R12 top and tags kept", 80'({top_o, tags_o}), 80'h0FF);
        setop(4'd9, 3'd5, '0, 80'h0, 1'b0); tick();
        peek(3'd5);
        check("R12 alias write ignored in stack mode", sti_o, {16'h3FF2, 64'hDEAD_BEEF_0123_4567});
        setop(4'd2, 3'd0, '0, '0, 1'b0);
        check("R4 pop after alias", st0_o, val(4));
        tick();
        check("R4 pop after alias state", 80'({top_o, tags_o}), 80'h1FE);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #12;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_push_pop();
        t_underflow();
        t_fill_overflow();
        t_xchg_wb();
        t_clear();
        t_alias();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule